// File: doc/BRIEF.md
# Memory-Mapped Operand and Result Shell for a 64-bit Arithmetic Unit

This block puts a 64-bit execution unit behind a 32-bit slave bus with a 5-bit address. A master loads two 64-bit operands through four 32-bit writes, high half first. It then fetches the 64-bit result through two 32-bit reads. Every access carries a 3-bit operation code in the top address bits. The code that comes with the final operand write is the one that starts the computation. When a master asks for a result that is not ready yet, the shell holds the bus off with waitrequest until the unit signals completion.

The arithmetic itself is not part of this block. A placeholder unit with a start/done handshake and a fixed, parameterised latency stands in for it. The placeholder combines the operands with a cheap integer or bitwise rule, so the shell can be verified end to end.

Top module: `fpu_bus_shell`

## Requirements
- R1: Reset (active low, asynchronous) clears both operands, the stored result, the result-valid state and the read data, and deasserts waitrequest. A read of the result after reset therefore stalls, and an operation started by a lone B-low write sees zeros in every other operand half.
- R2: An accepted write (bus_begin and bus_write both high, addressed by bus_addr[1:0]) loads the addressed operand half: 0 = A bits 63..32, 1 = A bits 31..0, 2 = B bits 63..32, 3 = B bits 31..0.
- R3: An accepted write to sub-address 3 produces exactly one start pulse in the following cycle. The operation code is taken from bus_addr[4:2] of that same write, whatever codes the earlier writes carried.
- R4: The placeholder unit computes the result from the operation code: 0 = A+B, 1 = A-B (modulo 2^64), 2 = A AND B, 3 = A OR B, 4 = A XOR B, 5 = A, 6 = B, 7 = NOT A. It signals done exactly CORE_LAT cycles after the start pulse.
- R5: An accepted read (bus_begin and bus_read high, bus_write low) at sub-address 0 or 1 with no valid result raises waitrequest in the next cycle. Waitrequest stays high until the done cycle and falls in the cycle after it. bus_rdata carries the addressed half in that cycle, with sub-address 0 returning bits 63..32 and sub-address 1 returning bits 31..0. When the read follows the B-low write directly, waitrequest is high for CORE_LAT cycles.
- R6: A result read that arrives while the result is valid completes without stall, with data on bus_rdata in the cycle after the access.
- R7: A result read issued before any operation was started keeps waitrequest high for as long as no result arrives.
- R8: Write, read and address levels without bus_begin change neither the operands nor waitrequest.
- R9: A read at sub-address 2 or 3 completes without stall and returns zero.
- R10: Accepting the B-low write invalidates the previous result, so a later result read stalls until the new result is done and returns the new value.
- R11: Waitrequest only rises in the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_begin | input | 1 | One-cycle marker of a bus access |
| bus_write | input | 1 | Write access |
| bus_read | input | 1 | Read access |
| bus_addr | input | 5 | [4:2] operation code, [1:0] register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_waitreq | output | 1 | Stall of a pending result read |

## Verification
The bound checker watches several rules on every cycle. It requires a start pulse to follow an accepted B-low write, and the result to be invalid while a start pulse is present. It checks that done arrives exactly CORE_LAT cycles after start, that waitrequest only rises after an accepted read and only falls after done, and that reads of the unused sub-addresses never stall. The data values need the bench's scenarios: the result for each operation code, the correct half on each read, the opcode taken from the last write, the stall length, the effect of ignored strobes and the cleared state after reset.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int OP_W   = 3;
  localparam int SUB_W  = 2;
  localparam int ADDR_W = OP_W + SUB_W;

  localparam logic [SUB_W-1:0] SEL_A_HI = 2'd0;
  localparam logic [SUB_W-1:0] SEL_A_LO = 2'd1;
  localparam logic [SUB_W-1:0] SEL_B_HI = 2'd2;
  localparam logic [SUB_W-1:0] SEL_B_LO = 2'd3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_PASSA = 3'd5,
    OP_PASSB = 3'd6,
    OP_NOTA  = 3'd7
  } op_e;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [OP_W-1:0]  op;
    logic [SUB_W-1:0] sub;
  } access_t;
endpackage

// File: rtl/fsh_bus_decode.sv
module fsh_bus_decode
  import fsh_pkg::*;
(
  input  logic              begin_i,
  input  logic              write_i,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] addr_i,
  output access_t           acc_o
);
  always_comb begin
    acc_o.wr  = begin_i & write_i;
    acc_o.rd  = begin_i & read_i & ~write_i;
    acc_o.op  = addr_i[ADDR_W-1 -: OP_W];
    acc_o.sub = addr_i[SUB_W-1:0];
  end
endmodule

// File: rtl/fsh_operand_regs.sv
module fsh_operand_regs
  import fsh_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OPND_W = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  access_t           acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [OPND_W-1:0] opa_o,
  output logic [OPND_W-1:0] opb_o,
  output logic [OP_W-1:0]   op_o,
  output logic              go_o,
  output logic              start_o
);
  logic [DATA_W-1:0] half_q [4];
  logic [DATA_W-1:0] half_d [4];
  logic [OP_W-1:0]   op_q, op_d;
  logic              start_q;

  assign go_o = acc_i.wr && (acc_i.sub == SEL_B_LO);

  for (genvar g = 0; g < 4; g++) begin : g_half
    always_comb begin
      half_d[g] = half_q[g];
      if (acc_i.wr && (acc_i.sub == SUB_W'(g)))
        half_d[g] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q[g] <= '0;
      else        half_q[g] <= half_d[g];
    end
  end

  always_comb begin
    op_d = op_q;
    if (go_o) op_d = acc_i.op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      start_q <= 1'b0;
    end else begin
      op_q    <= op_d;
      start_q <= go_o;
    end
  end

  assign opa_o   = {half_q[SEL_A_HI], half_q[SEL_A_LO]};
  assign opb_o   = {half_q[SEL_B_HI], half_q[SEL_B_LO]};
  assign op_o    = op_q;
  assign start_o = start_q;
endmodule

// File: rtl/fsh_stub_core.sv
module fsh_stub_core
  import fsh_pkg::*;
#(
  parameter int OPND_W   = 64,
  parameter int CORE_LAT = 4,
  localparam int CNT_W   = $clog2(CORE_LAT + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [OPND_W-1:0] opa_i,
  input  logic [OPND_W-1:0] opb_i,
  output logic              done_o,
  output logic [OPND_W-1:0] res_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OPND_W-1:0] res_q, res_d, calc;

  always_comb begin
    unique case (op_e'(op_i))
      OP_ADD:   calc = opa_i + opb_i;
      OP_SUB:   calc = opa_i - opb_i;
      OP_AND:   calc = opa_i & opb_i;
      OP_OR:    calc = opa_i | opb_i;
      OP_XOR:   calc = opa_i ^ opb_i;
      OP_PASSA: calc = opa_i;
      OP_PASSB: calc = opb_i;
      default:  calc = ~opa_i;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    res_d = res_q;
    if (start_i) begin
      cnt_d = CNT_W'(CORE_LAT);
      res_d = calc;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      res_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      res_q <= res_d;
    end
  end

  assign done_o = (cnt_q == CNT_W'(1));
  assign res_o  = res_q;
endmodule

// File: rtl/fsh_result_port.sv
module fsh_result_port
  import fsh_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OPND_W = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  access_t           acc_i,
  input  logic              go_i,
  input  logic              done_i,
  input  logic [OPND_W-1:0] core_res_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              waitreq_o,
  output logic              valid_o
);
  logic [OPND_W-1:0] res_q, res_d;
  logic              valid_q, valid_d;
  logic              pend_q, pend_d;
  logic              psel_q, psel_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              avail;
  logic [OPND_W-1:0] src;

  function automatic logic [DATA_W-1:0] pick(input logic [OPND_W-1:0] v, input logic lo);
    return lo ? v[DATA_W-1:0] : v[OPND_W-1:DATA_W];
  endfunction

  assign avail = valid_q | done_i;
  assign src   = done_i ? core_res_i : res_q;

  always_comb begin
    res_d   = res_q;
    valid_d = valid_q;
    pend_d  = pend_q;
    psel_d  = psel_q;
    rdata_d = rdata_q;
    if (done_i) begin
      res_d   = core_res_i;
      valid_d = 1'b1;
    end
    if (go_i) valid_d = 1'b0;
    if (pend_q) begin
      if (done_i) begin
        rdata_d = pick(core_res_i, psel_q);
        pend_d  = 1'b0;
      end
    end else if (acc_i.rd) begin
      if (acc_i.sub[1]) begin
        rdata_d = '0;
      end else if (avail) begin
        rdata_d = pick(src, acc_i.sub[0]);
      end else begin
        pend_d = 1'b1;
        psel_d = acc_i.sub[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      psel_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      res_q   <= res_d;
      valid_q <= valid_d;
      pend_q  <= pend_d;
      psel_q  <= psel_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o   = rdata_q;
  assign waitreq_o = pend_q;
  assign valid_o   = valid_q;
endmodule

// File: rtl/fpu_bus_shell.sv
module fpu_bus_shell
  import fsh_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CORE_LAT = 4,
  localparam int OPND_W  = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_begin,
  input  logic              bus_write,
  input  logic              bus_read,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_waitreq
);
  access_t           acc;
  logic [OPND_W-1:0] opa, opb, core_res;
  logic [OP_W-1:0]   op;
  logic              go, start_pulse, core_done, res_valid;

  fsh_bus_decode u_dec (
    .begin_i (bus_begin),
    .write_i (bus_write),
    .read_i  (bus_read),
    .addr_i  (bus_addr),
    .acc_o   (acc)
  );

  fsh_operand_regs #(.DATA_W(DATA_W)) u_opnd (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_i   (acc),
    .wdata_i (bus_wdata),
    .opa_o   (opa),
    .opb_o   (opb),
    .op_o    (op),
    .go_o    (go),
    .start_o (start_pulse)
  );

  fsh_stub_core #(.OPND_W(OPND_W), .CORE_LAT(CORE_LAT)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_pulse),
    .op_i    (op),
    .opa_i   (opa),
    .opb_i   (opb),
    .done_o  (core_done),
    .res_o   (core_res)
  );

  fsh_result_port #(.DATA_W(DATA_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_i      (acc),
    .go_i       (go),
    .done_i     (core_done),
    .core_res_i (core_res),
    .rdata_o    (bus_rdata),
    .waitreq_o  (bus_waitreq),
    .valid_o    (res_valid)
  );
endmodule

// File: rtl/fsh_checker.sv
module fsh_checker #(
  parameter int CORE_LAT = 4
)(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_begin,
  input logic       bus_write,
  input logic       bus_read,
  input logic [1:0] sub,
  input logic       bus_waitreq,
  input logic       start_pulse,
  input logic       core_done,
  input logic       res_valid
);
  logic        run_q;
  logic [31:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      age_q <= '0;
    end else if (start_pulse) begin
      run_q <= 1'b1;
      age_q <= 32'd1;
    end else if (core_done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      age_q <= age_q + 32'd1;
    end
  end

  assert_start_from_blo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(bus_begin && bus_write && sub == 2'd3));

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> (run_q && age_q == 32'(CORE_LAT)));

  assert_wait_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_waitreq) |-> $past(core_done));

  assert_unused_sub_nostall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_begin && bus_read && !bus_write && sub[1] && !bus_waitreq) |=> !bus_waitreq);

  assert_invalid_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !res_valid);

  assert_wait_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_waitreq) |-> $past(bus_begin && bus_read && !bus_write));
endmodule

bind fpu_bus_shell fsh_checker #(.CORE_LAT(CORE_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_begin   (bus_begin),
  .bus_write   (bus_write),
  .bus_read    (bus_read),
  .sub         (bus_addr[1:0]),
  .bus_waitreq (bus_waitreq),
  .start_pulse (start_pulse),
  .core_done   (core_done),
  .res_valid   (res_valid)
);

// File: tb/fpu_bus_shell_tb.sv
module fpu_bus_shell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;
  localparam int WATCHDOG   = 20000;

  logic        clk, rst_n, bus_begin, bus_write, bus_read, bus_waitreq;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done_run = 0;

  fpu_bus_shell #(.DATA_W(32), .CORE_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_begin(bus_begin), .bus_write(bus_write),
    .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done_run) begin
      done_run = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual cycles %0d expected < %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // op(3) | A(64) | B(64)
  localparam logic [130:0] VECS [8] = '{
    {3'd0, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000},
    {3'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {3'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001},
    {3'd2, 64'hF0F0_1234_AAAA_5555, 64'h0FFF_FF00_FFFF_0000},
    {3'd3, 64'h8000_0000_0000_0001, 64'h0000_0001_8000_0000},
    {3'd4, 64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_FFFF_0000},
    {3'd6, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888},
    {3'd7, 64'h0123_4567_89AB_CDEF, 64'h0}
  };

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a;
      3'd6: return b;
      default: return ~a;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] op, input logic [1:0] sub, input logic [31:0] d);
    bus_begin = 1; bus_write = 1; bus_read = 0;
    bus_addr = {op, sub}; bus_wdata = d;
    @(negedge clk);
    bus_begin = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [2:0] op, input logic [1:0] sub,
                        output logic [31:0] d, output int stall);
    stall = 0;
    bus_begin = 1; bus_read = 1; bus_write = 0; bus_addr = {op, sub};
    @(negedge clk);
    bus_begin = 0;
    while (bus_waitreq && stall < 1000) begin
      stall++;
      @(negedge clk);
    end
    d = bus_rdata;
    bus_read = 0;
  endtask

  task automatic load(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    bus_wr(op, 2'd0, a[63:32]);
    bus_wr(op, 2'd1, a[31:0]);
    bus_wr(op, 2'd2, b[63:32]);
    bus_wr(op, 2'd3, b[31:0]);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] hi, lo;
    int st, st2;
    logic [63:0] exp;
    rst_n = 0; bus_begin = 0; bus_write = 0; bus_read = 0;
    bus_addr = '0; bus_wdata = '0;
    @(negedge clk);
    do_reset();

    // R1: reset state at the ports
    check(bus_waitreq == 1'b0, "R1 waitreq after reset", 64'(bus_waitreq), 64'd0);
    check(bus_rdata == 32'd0, "R1 rdata after reset", 64'(bus_rdata), 64'd0);

    // Vector table: R2, R4, R5, R6
    foreach (VECS[i]) begin
      logic [2:0]  vop = VECS[i][130:128];
      logic [63:0] va  = VECS[i][127:64];
      logic [63:0] vb  = VECS[i][63:0];
      exp = model(vop, va, vb);
      load(vop, va, vb);
      bus_rd(vop, 2'd0, hi, st);
      bus_rd(vop, 2'd1, lo, st2);
      check({hi, lo} == exp, "R4 R2 result value", {hi, lo}, exp);
      check(st == LAT, "R5 stall length", 64'(st), 64'(LAT));
      check(st2 == 0, "R6 low half no stall", 64'(st2), 64'd0);
    end

    // R6: repeated read of a valid high half, no stall
    bus_rd(3'd0, 2'd0, hi, st);
    check(st == 0 && hi == exp[63:32], "R6 reread valid hi", {32'(st), hi}, {32'd0, exp[63:32]});

    // R9: unused sub-addresses read zero without stall
    bus_rd(3'd0, 2'd2, hi, st);
    check(st == 0 && hi == 0, "R9 sub2 read", {32'(st), hi}, 64'd0);
    bus_rd(3'd5, 2'd3, hi, st);
    check(st == 0 && hi == 0, "R9 sub3 read", {32'(st), hi}, 64'd0);

    // R3: opcode taken from the B-low write only
    bus_wr(3'd0, 2'd0, 32'hAAAA_0000);
    bus_wr(3'd0, 2'd1, 32'h0000_FFFF);
    bus_wr(3'd0, 2'd2, 32'h0F0F_0F0F);
    bus_wr(3'd4, 2'd3, 32'h1234_5678);
    exp = 64'hAAAA_0000_0000_FFFF ^ 64'h0F0F_0F0F_1234_5678;
    bus_rd(3'd1, 2'd0, hi, st);
    bus_rd(3'd2, 2'd1, lo, st2);
    check({hi, lo} == exp, "R3 opcode from last write", {hi, lo}, exp);

    // R8: strobes without bus_begin are ignored
    load(3'd5, 64'h0102_0304_0506_0708, 64'h0);
    bus_rd(3'd5, 2'd0, hi, st);
    bus_write = 1; bus_addr = {3'd5, 2'd0}; bus_wdata = 32'hDEAD_DEAD;
    @(negedge clk);
    bus_write = 0; bus_read = 1; bus_addr = {3'd5, 2'd0};
    @(negedge clk);
    check(bus_waitreq == 0, "R8 read without begin", 64'(bus_waitreq), 64'd0);
    bus_read = 0;
    bus_wr(3'd5, 2'd3, 32'h0);
    bus_rd(3'd5, 2'd0, hi, st);
    bus_rd(3'd5, 2'd1, lo, st2);
    check({hi, lo} == 64'h0102_0304_0506_0708, "R8 write without begin", {hi, lo}, 64'h0102_0304_0506_0708);

    // R10: new start invalidates the old result; low half read stalls
    load(3'd6, 64'h0, 64'hCAFE_F00D_BEEF_0001);
    bus_rd(3'd6, 2'd1, lo, st);
    check(st == LAT && lo == 32'hBEEF_0001, "R10 stall then new lo", {32'(st), lo}, {32'(LAT), 32'hBEEF_0001});
    bus_rd(3'd6, 2'd0, hi, st);
    check(st == 0 && hi == 32'hCAFE_F00D, "R10 hi after lo", {32'(st), hi}, {32'd0, 32'hCAFE_F00D});

    // R1: operands cleared by reset; lone B-low write passes zeros
    do_reset();
    bus_wr(3'd0, 2'd3, 32'h0000_0042);
    bus_rd(3'd0, 2'd0, hi, st);
    bus_rd(3'd0, 2'd1, lo, st2);
    check({hi, lo} == 64'h42, "R1 operands cleared", {hi, lo}, 64'h42);

    // R7 + R11: read with no operation ever started stalls indefinitely
    do_reset();
    bus_begin = 1; bus_read = 1; bus_write = 0; bus_addr = {3'd0, 2'd0};
    @(negedge clk);
    bus_begin = 0;
    st = 0;
    repeat (20) begin
      if (bus_waitreq) st++;
      @(negedge clk);
    end
    check(st == 20, "R7 stall persists", 64'(st), 64'd20);
    bus_read = 0;
    // R1: reset releases the stall
    rst_n = 0;
    @(negedge clk);
    check(bus_waitreq == 0, "R1 reset drops waitreq", 64'(bus_waitreq), 64'd0);
    rst_n = 1;
    @(negedge clk);

    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule